// File: doc/BRIEF.md
# Serial-Bus Slave for a One-Time-Programmable 64-Step Potentiometer

This block is the digital front end of a 64-step potentiometer that sits on a two-wire I2C-compatible bus. It watches the clock and data lines by oversampling them on its own system clock. It recognises bus START and STOP conditions and answers to one of two 7-bit addresses. A strap pin selects which of the two it uses. The block holds the 6-bit wiper code that sets the resistor tap.

A write transaction carries three kinds of byte in order: the address, one instruction byte, and then one or more data bytes. Every data byte that is acknowledged loads the wiper. If the top bit of the instruction is set, a data byte also requests permanent programming. In that case the block emits a one-cycle strobe toward the fuse circuitry and freezes the wiper. A read transaction returns the wiper code straight after the address acknowledge. The master may acknowledge that byte to get the value again, or decline it to end the read.

The block drives the data line only through an open-drain pull-down enable and never holds the clock.

Top module: `otp_pot_slave`

## Requirements
- R1: After reset the wiper reads 0, the strobe is low and SDA is released. A STOP (SDA rising while SCL is high) returns the slave to idle with SDA released.
- R2: The address byte after a START is matched when its bits [7:2] equal 6'b010110 and bit 1 equals the strap input. Bit 0 selects read (1) or write (0). On a match the slave pulls SDA low for the ninth SCL pulse.
- R3: A non-matching address is not acknowledged, and the slave ignores all further bytes until the next START. The wiper is left unchanged.
- R4: In a write, the byte after the address is the instruction byte and is acknowledged. Each following data byte is acknowledged, and once its acknowledge clock ends the wiper takes data bits [5:0]. Data bits [7:6] are ignored.
- R5: Further data bytes in the same write transaction each update the wiper again, until a STOP.
- R6: In a read, the byte {2'b00, wiper} is sent MSB first straight after the address acknowledge. If the master acknowledges, the same value is sent again. If the master does not acknowledge, the read ends.
- R7: A data byte written under an instruction whose bit 7 is 1 is acknowledged and loads the wiper. It also raises the program strobe for exactly one system clock.
- R8: After a program strobe, later data bytes are still acknowledged, but the wiper never changes and no further strobe occurs until reset.
- R9: A START seen in the middle of any byte restarts address reception. A complete transaction that follows it behaves normally.
- R10: The SDA pull-down enable changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the SCL rate |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| addr_strap_i | input | 1 | Strap pin that selects address bit 1 |
| sda_oe_o | output | 1 | High pulls SDA low (open-drain enable) |
| wiper_o | output | 6 | Current wiper code |
| prog_strobe_o | output | 1 | One-cycle request to blow the program fuses |

## Verification
The hardest situations to reach from the ports are a START that cuts into a half-sent data byte, and a write that arrives after the lock is set. The lock case is hard because the lock itself cannot be seen. In the first case the bench clocks four data bits and then produces a START from the SCL-low phase. It then checks that a fresh write is acknowledged and lands correctly. For the lock, the bench counts strobe pulses on the port. It then sends more data bytes, both in the same transaction and in a new one, and reads the wiper back over the bus to confirm that it did not move.

// File: rtl/potslv_pkg.sv
// Shared types for the potentiometer bus slave.
package potslv_pkg;
    // Protocol sequencer states.
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_INSTR,
        ST_WDATA,
        ST_ACK,
        ST_RDATA,
        ST_RACK
    } slv_state_t;
endpackage

// File: rtl/potslv_lines.sv
// Line conditioner: synchronises SCL and SDA into the system clock domain,
// then derives SCL edges and START/STOP events.
// Assumes the system clock is at least 8x faster than SCL and that
// STAGES >= 2.
module potslv_lines #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [STAGES-1:0] scl_p, sda_p;
    logic scl_q, sda_q;

    // Synchroniser chains plus one delayed copy for edge detection; idle bus is high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_p <= '1;
            sda_p <= '1;
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_p <= {scl_p[STAGES-2:0], scl_i};
            sda_p <= {sda_p[STAGES-2:0], sda_i};
            scl_q <= scl_p[STAGES-1];
            sda_q <= sda_p[STAGES-1];
        end
    end

    assign scl_s     = scl_p[STAGES-1];
    assign sda_s     = sda_p[STAGES-1];
    assign scl_rise  = scl_s & ~scl_q;
    assign scl_fall  = ~scl_s & scl_q;
    assign start_det = scl_s & scl_q & sda_q & ~sda_s;
    assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/potslv_proto.sv
// Protocol sequencer: shifts bytes in and out on SCL edges, matches the
// address, drives acknowledges and read data through an open-drain enable,
// and issues one write request per acknowledged data byte.
// Assumes conditioned SCL/SDA and event pulses from potslv_lines.
module potslv_proto
    import potslv_pkg::*;
#(
    parameter int          BYTE_W  = 8,
    parameter int          WIPER_W = 6,
    parameter int          ID_W    = 6,
    parameter logic [ID_W-1:0] DEV_ID = 6'b010110
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sda_s,
    input  logic               scl_rise,
    input  logic               scl_fall,
    input  logic               start_det,
    input  logic               stop_det,
    input  logic               strap,
    input  logic [WIPER_W-1:0] rd_value,
    output logic               sda_oe,
    output logic               wr_en,
    output logic [WIPER_W-1:0] wr_data,
    output logic               wr_otp
);
    localparam int CNT_W = $clog2(BYTE_W + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W);

    slv_state_t         state, after;
    logic [CNT_W-1:0]   cnt;
    logic [BYTE_W-1:0]  shreg, txreg;
    logic               wr_pend, mack;
    logic [BYTE_W-1:0]  rd_byte;
    logic               addr_hit;

    // Read byte is the wiper with zero-filled upper bits; address compare.
    assign rd_byte  = {{(BYTE_W-WIPER_W){1'b0}}, rd_value};
    assign addr_hit = (shreg[BYTE_W-1 -: ID_W] == DEV_ID) && (shreg[1] == strap);

    // Sequencer: byte reception, acknowledge, read transmission.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            after   <= ST_IDLE;
            cnt     <= '0;
            shreg   <= '0;
            txreg   <= '0;
            sda_oe  <= 1'b0;
            wr_en   <= 1'b0;
            wr_data <= '0;
            wr_otp  <= 1'b0;
            wr_pend <= 1'b0;
            mack    <= 1'b0;
        end else begin
            wr_en <= 1'b0;
            if (start_det) begin
                state   <= ST_ADDR;
                cnt     <= '0;
                sda_oe  <= 1'b0;
                wr_pend <= 1'b0;
            end else if (stop_det) begin
                state   <= ST_IDLE;
                sda_oe  <= 1'b0;
                wr_pend <= 1'b0;
            end else begin
                case (state)
                    ST_ADDR, ST_INSTR, ST_WDATA: begin
                        if (scl_rise) begin
                            shreg <= {shreg[BYTE_W-2:0], sda_s};
                            cnt   <= cnt + 1'b1;
                        end else if (scl_fall && cnt == LAST) begin
                            cnt <= '0;
                            if (state == ST_ADDR) begin
                                if (addr_hit) begin
                                    sda_oe <= 1'b1;
                                    state  <= ST_ACK;
                                    after  <= shreg[0] ? ST_RDATA : ST_INSTR;
                                end else begin
                                    state <= ST_IDLE;
                                end
                            end else if (state == ST_INSTR) begin
                                wr_otp <= shreg[BYTE_W-1];
                                sda_oe <= 1'b1;
                                state  <= ST_ACK;
                                after  <= ST_WDATA;
                            end else begin
                                wr_data <= shreg[WIPER_W-1:0];
                                wr_pend <= 1'b1;
                                sda_oe  <= 1'b1;
                                state   <= ST_ACK;
                                after   <= ST_WDATA;
                            end
                        end
                    end
                    ST_ACK: begin
                        if (scl_fall) begin
                            state <= after;
                            cnt   <= '0;
                            if (wr_pend) begin
                                wr_en   <= 1'b1;
                                wr_pend <= 1'b0;
                            end
                            if (after == ST_RDATA) begin
                                sda_oe <= ~rd_byte[BYTE_W-1];
                                txreg  <= {rd_byte[BYTE_W-2:0], 1'b0};
                            end else begin
                                sda_oe <= 1'b0;
                            end
                        end
                    end
                    ST_RDATA: begin
                        if (scl_rise) begin
                            cnt <= cnt + 1'b1;
                        end else if (scl_fall) begin
                            if (cnt == LAST) begin
                                sda_oe <= 1'b0;
                                state  <= ST_RACK;
                            end else begin
                                sda_oe <= ~txreg[BYTE_W-1];
                                txreg  <= {txreg[BYTE_W-2:0], 1'b0};
                            end
                        end
                    end
                    ST_RACK: begin
                        if (scl_rise) begin
                            mack <= ~sda_s;
                        end else if (scl_fall) begin
                            if (mack) begin
                                state  <= ST_RDATA;
                                cnt    <= '0;
                                sda_oe <= ~rd_byte[BYTE_W-1];
                                txreg  <= {rd_byte[BYTE_W-2:0], 1'b0};
                            end else begin
                                state <= ST_IDLE;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/potslv_wiper.sv
// Wiper register with one-time-program lock: loads on write requests until
// a programming write sets the sticky lock, which only reset clears.
// Assumes write requests are single-cycle pulses.
module potslv_wiper #(
    parameter int WIPER_W = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [WIPER_W-1:0] wr_data,
    input  logic               wr_otp,
    output logic [WIPER_W-1:0] wiper,
    output logic               prog_strobe
);
    logic locked;

    // Wiper load, one-cycle program strobe and sticky lock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wiper       <= '0;
            prog_strobe <= 1'b0;
            locked      <= 1'b0;
        end else begin
            prog_strobe <= 1'b0;
            if (wr_en && !locked) begin
                wiper <= wr_data;
                if (wr_otp) begin
                    prog_strobe <= 1'b1;
                    locked      <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/otp_pot_slave.sv
// Top level of the potentiometer bus slave: line conditioner, protocol
// sequencer and wiper/lock register.
// Assumes clk is at least 8x the SCL rate; SDA is open-drain (sda_oe_o=1 pulls low).
module otp_pot_slave #(
    parameter int              SYNC_STAGES = 2,
    parameter int              BYTE_W      = 8,
    parameter int              WIPER_W     = 6,
    parameter int              ID_W        = 6,
    parameter logic [ID_W-1:0] DEV_ID      = 6'b010110
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               scl_i,
    input  logic               sda_i,
    input  logic               addr_strap_i,
    output logic               sda_oe_o,
    output logic [WIPER_W-1:0] wiper_o,
    output logic               prog_strobe_o
);
    logic scl_sync, sda_sync, scl_up, scl_dn, start_seen, stop_seen;
    logic wr_en;
    logic [WIPER_W-1:0] wr_data;
    logic wr_otp;

    potslv_lines #(.STAGES(SYNC_STAGES)) u_lines (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_s(scl_sync), .sda_s(sda_sync), .scl_rise(scl_up), .scl_fall(scl_dn),
        .start_det(start_seen), .stop_det(stop_seen)
    );

    potslv_proto #(.BYTE_W(BYTE_W), .WIPER_W(WIPER_W), .ID_W(ID_W), .DEV_ID(DEV_ID)) u_proto (
        .clk(clk), .rst_n(rst_n), .sda_s(sda_sync), .scl_rise(scl_up), .scl_fall(scl_dn),
        .start_det(start_seen), .stop_det(stop_seen), .strap(addr_strap_i),
        .rd_value(wiper_o), .sda_oe(sda_oe_o), .wr_en(wr_en), .wr_data(wr_data),
        .wr_otp(wr_otp)
    );

    potslv_wiper #(.WIPER_W(WIPER_W)) u_wiper (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .wr_otp(wr_otp),
        .wiper(wiper_o), .prog_strobe(prog_strobe_o)
    );
endmodule

// File: rtl/potslv_chk.sv
// Assertion checker for otp_pot_slave, attached by bind.
// Assumes it observes the synchronised SCL and the STOP event of the top.
module potslv_chk #(
    parameter int WIPER_W = 6
) (
    input logic               clk,
    input logic               rst_n,
    input logic               scl_s,
    input logic               stop_det,
    input logic               sda_oe,
    input logic [WIPER_W-1:0] wiper,
    input logic               strobe
);
    logic seen_q;

    // Remembers that a program strobe has occurred since reset.
    always_ff @(posedge clk) begin
        if (!rst_n) seen_q <= 1'b0;
        else if (strobe) seen_q <= 1'b1;
    end

    AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |=> !strobe); // R7
    AST_ONE_PROGRAM: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |-> !seen_q); // R8
    AST_LOCK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        seen_q |-> $stable(wiper)); // R8
    AST_STOP_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !sda_oe); // R1
    AST_OE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> !scl_s); // R10
endmodule

bind otp_pot_slave potslv_chk #(.WIPER_W(WIPER_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_sync), .stop_det(stop_seen),
    .sda_oe(sda_oe_o), .wiper(wiper_o), .strobe(prog_strobe_o)
);

// File: tb/otp_pot_slave_tb.sv
// Directed bench for otp_pot_slave: a bit-level bus master with one task per scenario.
module otp_pot_slave_tb;
    localparam int Q = 8;  // system clocks per quarter SCL period

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tb_scl = 1'b1;
    logic tb_sda_low = 1'b0;
    logic strap = 1'b1;
    logic sda_bus;
    logic dut_oe;
    logic [5:0] wiper;
    logic strobe;
    int   tests = 0;
    int   fails = 0;
    int   strobes = 0;
    int   oe_bad = 0;
    logic oe_prev = 1'b0;
    bit   done = 1'b0;

    always #5 clk = ~clk;
    assign sda_bus = ~(tb_sda_low | dut_oe);

    otp_pot_slave u_dut (
        .clk(clk), .rst_n(rst_n), .scl_i(tb_scl), .sda_i(sda_bus),
        .addr_strap_i(strap), .sda_oe_o(dut_oe), .wiper_o(wiper),
        .prog_strobe_o(strobe)
    );

    // Port monitors: strobe pulses and enable changes while SCL is high.
    always @(posedge clk) begin
        if (rst_n && strobe) strobes++;
        if (rst_n && dut_oe != oe_prev && tb_scl) oe_bad++;
        oe_prev <= dut_oe;
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic bus_start();
        tb_sda_low = 1'b0; tick(Q);
        tb_scl = 1'b1;     tick(Q);
        tb_sda_low = 1'b1; tick(Q);
        tb_scl = 1'b0;     tick(Q);
    endtask

    task automatic bus_stop();
        tb_sda_low = 1'b1; tick(Q);
        tb_scl = 1'b1;     tick(Q);
        tb_sda_low = 1'b0; tick(Q);
    endtask

    task automatic send_bit(input logic b);
        tb_sda_low = ~b; tick(Q);
        tb_scl = 1'b1;   tick(2*Q);
        tb_scl = 1'b0;   tick(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
        tb_sda_low = 1'b0; tick(Q);
        tb_scl = 1'b1;     tick(Q);
        ack = ~sda_bus;    tick(Q);
        tb_scl = 1'b0;     tick(Q);
    endtask

    task automatic read_byte(input logic give_ack, output logic [7:0] v);
        tb_sda_low = 1'b0;
        for (int i = 7; i >= 0; i--) begin
            tick(Q); tb_scl = 1'b1;
            tick(Q); v[i] = sda_bus;
            tick(Q); tb_scl = 1'b0;
        end
        tb_sda_low = give_ack; tick(Q);
        tb_scl = 1'b1;         tick(2*Q);
        tb_scl = 1'b0;         tick(Q);
        tb_sda_low = 1'b0;
    endtask

    function automatic logic [7:0] addr(input logic s, input logic rd);
        return {6'b010110, s, rd};
    endfunction

    task automatic t_reset();
        chk("R1 reset wiper", wiper, 0);
        chk("R1 reset strobe", strobe, 0);
        chk("R1 reset sda_oe", dut_oe, 0);
    endtask

    task automatic t_write_basic();
        logic a;
        bus_start();
        send_byte(addr(1'b1, 1'b0), a); chk("R2 address ack", a, 1);
        send_byte(8'h00, a);            chk("R4 instruction ack", a, 1);
        send_byte(8'h2A, a);            chk("R4 data ack", a, 1);
        chk("R4 wiper after data", wiper, 6'h2A);
        bus_stop();
        chk("R1 sda released after stop", dut_oe, 0);
    endtask

    task automatic t_write_repeat();
        logic a;
        bus_start();
        send_byte(addr(1'b1, 1'b0), a);
        send_byte(8'h00, a);
        send_byte(8'h05, a); chk("R5 first data", wiper, 6'h05);
        send_byte(8'hFF, a); chk("R5 second data, R4 upper bits dropped", wiper, 6'h3F);
        chk("R5 second data ack", a, 1);
        bus_stop();
    endtask

    task automatic t_read(input logic [7:0] exp);
        logic a;
        logic [7:0] v;
        bus_start();
        send_byte(addr(1'b1, 1'b1), a); chk("R2 read address ack", a, 1);
        read_byte(1'b1, v);             chk("R6 first read byte", v, exp);
        read_byte(1'b0, v);             chk("R6 repeated read byte", v, exp);
        bus_stop();
        chk("R6 released after read", dut_oe, 0);
    endtask

    task automatic t_wrong_addr();
        logic a;
        bus_start();
        send_byte(addr(1'b0, 1'b0), a); chk("R3 no ack on other address", a, 0);
        send_byte(8'h00, a);            chk("R3 instruction ignored", a, 0);
        send_byte(8'h01, a);            chk("R3 data ignored", a, 0);
        chk("R3 wiper unchanged", wiper, 6'h3F);
        bus_stop();
    endtask

    task automatic t_restart();
        logic a;
        bus_start();
        send_byte(addr(1'b1, 1'b0), a);
        send_byte(8'h00, a);
        for (int i = 0; i < 4; i++) send_bit(1'b0);
        bus_start();
        send_byte(addr(1'b1, 1'b0), a); chk("R9 address ack after restart", a, 1);
        send_byte(8'h00, a);
        send_byte(8'h11, a);            chk("R9 data ack after restart", a, 1);
        chk("R9 wiper after restart", wiper, 6'h11);
        bus_stop();
    endtask

    task automatic t_program();
        logic a;
        chk("R7 no strobe before programming", strobes, 0);
        bus_start();
        send_byte(addr(1'b1, 1'b0), a);
        send_byte(8'h80, a);  chk("R7 program instruction ack", a, 1);
        send_byte(8'h19, a);  chk("R7 program data ack", a, 1);
        chk("R7 wiper loaded", wiper, 6'h19);
        chk("R7 one strobe", strobes, 1);
        send_byte(8'h07, a);  chk("R8 later data still acked", a, 1);
        chk("R8 wiper frozen same transaction", wiper, 6'h19);
        bus_stop();
        bus_start();
        send_byte(addr(1'b1, 1'b0), a);
        send_byte(8'h80, a);
        send_byte(8'h22, a);
        chk("R8 wiper frozen new transaction", wiper, 6'h19);
        chk("R8 no second strobe", strobes, 1);
        bus_stop();
    endtask

    initial begin
        tick(4);
        rst_n = 1'b1;
        tick(4);
        t_reset();
        t_write_basic();
        t_write_repeat();
        t_read(8'h3F);
        t_wrong_addr();
        t_restart();
        t_program();
        t_read(8'h19);
        chk("R10 enable changed only while SCL low", oe_bad, 0);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule